// File: doc/BRIEF.md
# Frame-Sync Edge Interrupt Detector

This block watches the frame-sync line of a serial port and gives the CPU a single-clock interrupt pulse each time a new frame begins. The sync comes either from an external pin or from the port's internal generator. A select bit picks the source and a polarity bit sets the active level, as in the serial port itself. The chosen level is brought into the CPU clock domain through a flop synchronizer. A registered edge detector then fires only on an inactive-to-active change.

The sync-edge behaviour is chosen by the two-bit interrupt-mode value 2'b10. The detector keeps running while the serial port is held in its own reset. Software can therefore wait for a frame start and release the port in step with it. For any other mode value the sync edges are masked, and the interrupt output is a registered copy of a word-ready input from the port. That copy is forced low while the port is in reset.

Top module: `fsync_irq_detect`

## Requirements
- R1: While `rst_n` is low, `irq` is 0. After release it stays 0 for as long as the selected sync is at its inactive level, whatever the polarity setting.
- R2: `src_sel` = 0 selects `sync_pin` and `src_sel` = 1 selects `sync_int`. Activity on the unselected line produces no interrupt.
- R3: With `pol_sel` = 0 a high level is active. With `pol_sel` = 1 a low level is active.
- R4: With `irq_mode` = 2'b10, an inactive-to-active change produces one `irq` pulse exactly one clock wide. The pulse appears after the third rising clock edge counted from the edge that first samples the active level. The count is SYNC_STAGES+1 edges, and SYNC_STAGES defaults to 2.
- R5: A sync held active for many cycles gives only one interrupt. The next interrupt needs the line to go inactive and then active again, and an active level lasting one clock is enough.
- R6: For any `irq_mode` other than 2'b10, sync edges are ignored and `irq` equals `word_rdy & ~port_rst` registered one clock.
- R7: With `irq_mode` = 2'b10, `port_rst` has no effect: sync edges raise `irq` while the port is held in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| sync_pin | input | 1 | Frame sync from the external pin |
| sync_int | input | 1 | Frame sync generated inside the port |
| src_sel | input | 1 | Sync source: 0 pin, 1 internal |
| pol_sel | input | 1 | Sync polarity: 0 active high, 1 active low |
| irq_mode | input | 2 | Interrupt mode; 2'b10 selects sync-edge interrupts |
| port_rst | input | 1 | Serial port held in reset (masks only the word-ready path) |
| word_rdy | input | 1 | Word-ready event from the port, used in the other modes |
| irq | output | 1 | Interrupt pulse to the CPU |

## Verification
The hardest case to reach is a setting change that itself creates a false edge. Flipping the polarity or the source while the two candidate levels differ changes the normalized level even though no sync pulse arrived. The stimulus first parks the lines so the change is neutral. It then also makes such changes on purpose during a random phase, where a cycle-accurate queue model predicts the resulting pulse. A long hold of the active level, and a long hold inside port reset, show that only one pulse and no repeats appear.

// File: rtl/fsirq_pkg.sv
package fsirq_pkg;
   localparam int unsigned IRQ_MODE_W = 2;
   localparam logic [IRQ_MODE_W-1:0] MODE_FSYNC_EDGE = 2'b10;

   typedef enum logic {
      SRC_PIN      = 1'b0,
      SRC_INTERNAL = 1'b1
   } sync_src_e;
endpackage

// File: rtl/fsirq_level_sel.sv
module fsirq_level_sel (
   input  logic sync_pin,
   input  logic sync_int,
   input  logic src_sel,
   input  logic pol_sel,
   output logic level_o
);
   import fsirq_pkg::*;

   logic raw;

   always_comb begin
      raw     = (sync_src_e'(src_sel) == SRC_INTERNAL) ? sync_int : sync_pin;
      level_o = raw ^ pol_sel;
   end
endmodule

// File: rtl/fsirq_sync.sv
module fsirq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("fsirq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fsirq_edge.sv
module fsirq_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);
   logic prev_q;

   // Loaded with the inactive level so reset release never looks like an edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign rise_o = level_i & ~prev_q;

   p_rise_isolated_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/fsync_irq_detect.sv
module fsync_irq_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_pin,
   input  logic       sync_int,
   input  logic       src_sel,
   input  logic       pol_sel,
   input  logic [1:0] irq_mode,
   input  logic       port_rst,
   input  logic       word_rdy,
   output logic       irq
);
   import fsirq_pkg::*;

   localparam int unsigned LATENCY = SYNC_STAGES + 1;

   generate
      if (LATENCY < 3) begin : g_bad_latency
         $error("fsync_irq_detect: synchronizer too shallow");
      end
   endgenerate

   logic level_raw;
   logic level_sync;
   logic sync_rise;
   logic fsync_mode;

   fsirq_level_sel i_sel (
      .sync_pin (sync_pin),
      .sync_int (sync_int),
      .src_sel  (src_sel),
      .pol_sel  (pol_sel),
      .level_o  (level_raw)
   );

   fsirq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (level_raw),
      .q     (level_sync)
   );

   fsirq_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (level_sync),
      .rise_o  (sync_rise)
   );

   assign fsync_mode = (irq_mode == MODE_FSYNC_EDGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq <= 1'b0;
      else if (fsync_mode) irq <= sync_rise;
      else                 irq <= word_rdy & ~port_rst;
   end

   // R6: other modes copy the word-ready path one clock later
   p_word_path_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mode != MODE_FSYNC_EDGE) |=> (irq == $past(word_rdy & ~port_rst)));

   // R4: a sync-mode pulse is backed by a rise on the synchronized level
   p_irq_from_rise_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && $past(irq_mode) == MODE_FSYNC_EDGE) |-> ($past(level_sync, 1) && !$past(level_sync, 2)));

   // R5: two sync-mode pulses never abut
   p_no_back_to_back_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_mode == MODE_FSYNC_EDGE && $past(irq_mode) == MODE_FSYNC_EDGE) |=> !irq);

   // R7: port reset does not mask a sync-mode pulse
   p_port_rst_transparent_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (fsync_mode && sync_rise) |=> irq);
endmodule

// File: tb/test_fsync_irq_detect.sv
module test_fsync_irq_detect;
   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_pin = 1'b0, sync_int = 1'b0, src_sel = 1'b0, pol_sel = 1'b0;
   logic [1:0] irq_mode = 2'b10;
   logic       port_rst = 1'b0, word_rdy = 1'b0;
   logic       irq;

   int tests = 0, fails = 0, pulses = 0;
   bit exp_irq = 1'b0;
   bit hist[$];
   bit done = 1'b0;

   always #5 clk = ~clk;

   fsync_irq_detect #(.SYNC_STAGES(S)) i_fsync_irq_detect (
      .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .sync_int(sync_int),
      .src_sel(src_sel), .pol_sel(pol_sel), .irq_mode(irq_mode),
      .port_rst(port_rst), .word_rdy(word_rdy), .irq(irq));

   // Reference model: queue of normalized sync samples, one per clock.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {};
         for (int i = 0; i < S + 2; i++) hist.push_back(1'b0);
         exp_irq = 1'b0;
      end else begin
         hist.push_front((src_sel ? sync_int : sync_pin) ^ pol_sel);
         void'(hist.pop_back());
         if (irq_mode == 2'b10) exp_irq = hist[S] & ~hist[S+1];
         else                   exp_irq = word_rdy & ~port_rst;
      end
   end

   task automatic check(input string req, input bit act, input bit exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_cnt(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual count %0d expected %0d", req, act, exp);
      end
   endtask

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) check("R1", irq, 1'b0);
         else check((irq_mode == 2'b10) ? "R4" : "R6", irq, exp_irq);
         if (irq) pulses++;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2000000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R1: active-low polarity, inactive (high) pin across reset release
      pol_sel = 1'b1; sync_pin = 1'b1;
      cycles(3);
      check("R1", irq, 1'b0);
      rst_n = 1'b1;
      pulses = 0; cycles(10);
      check_cnt("R1", pulses, 0);

      // R3: active-low level produces one pulse
      sync_pin = 1'b0;
      pulses = 0; cycles(8);
      check_cnt("R3", pulses, 1);
      sync_pin = 1'b1; cycles(4);
      // neutral switch to active-high
      sync_pin = 1'b0; pol_sel = 1'b0; cycles(4);
      pulses = 0; cycles(4);
      check_cnt("R3", pulses, 0);

      // R4: exact latency and width
      sync_pin = 1'b1;
      cycles(1); check("R4", irq, 1'b0);
      cycles(1); check("R4", irq, 1'b0);
      cycles(1); check("R4", irq, 1'b1);
      cycles(1); check("R4", irq, 1'b0);

      // R5: long active hold gives nothing more; one-clock pulse is seen
      pulses = 0; cycles(20);
      check_cnt("R5", pulses, 0);
      sync_pin = 1'b0; cycles(3);
      sync_pin = 1'b1; cycles(1);
      sync_pin = 1'b0;
      pulses = 0; cycles(6);
      check_cnt("R5", pulses, 1);

      // R2: unselected internal line toggling is ignored
      pulses = 0;
      for (int k = 0; k < 5; k++) begin
         sync_int = 1'b1; cycles(2);
         sync_int = 1'b0; cycles(2);
      end
      cycles(4);
      check_cnt("R2", pulses, 0);
      src_sel = 1'b1; cycles(4);
      pulses = 0;
      for (int k = 0; k < 4; k++) begin
         sync_int = 1'b1; sync_pin = ~sync_pin; cycles(2);
         sync_int = 1'b0; cycles(2);
      end
      cycles(4);
      check_cnt("R2", pulses, 4);

      // R7: port reset does not stop sync-mode interrupts
      port_rst = 1'b1;
      pulses = 0;
      for (int k = 0; k < 3; k++) begin
         sync_int = 1'b1; cycles(10);
         sync_int = 1'b0; cycles(3);
      end
      cycles(4);
      check_cnt("R7", pulses, 3);
      port_rst = 1'b0;

      // R6: other modes follow word_rdy, sync edges masked
      irq_mode = 2'b00; sync_int = 1'b0; cycles(4);
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
         word_rdy = 1'b1; sync_int = 1'b1; cycles(1);
         word_rdy = 1'b0; sync_int = 1'b0; cycles(2);
      end
      cycles(2);
      check_cnt("R6", pulses, 6);
      word_rdy = 1'b1; cycles(1);
      check("R6", irq, 1'b1);
      port_rst = 1'b1; cycles(1);
      check("R6", irq, 1'b0);
      irq_mode = 2'b11; port_rst = 1'b0; cycles(1);
      check("R6", irq, 1'b1);
      irq_mode = 2'b01; word_rdy = 1'b0; cycles(1);
      check("R6", irq, 1'b0);

      // Random phase including deliberate source and polarity flips
      for (int k = 0; k < 600; k++) begin
         sync_pin = 1'($urandom_range(0, 1));
         sync_int = 1'($urandom_range(0, 1));
         word_rdy = 1'($urandom_range(0, 1));
         port_rst = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 7) == 0) src_sel = ~src_sel;
         if ($urandom_range(0, 7) == 0) pol_sel = ~pol_sel;
         if ($urandom_range(0, 15) == 0) irq_mode = 2'($urandom_range(0, 3));
         else if ($urandom_range(0, 3) == 0) irq_mode = 2'b10;
         cycles(1);
      end

      // R1: mid-run global reset clears the output
      rst_n = 1'b0; cycles(2);
      check("R1", irq, 1'b0);
      sync_pin = 1'b0; sync_int = 1'b0; pol_sel = 1'b0; irq_mode = 2'b10;
      rst_n = 1'b1;
      pulses = 0; cycles(8);
      check_cnt("R1", pulses, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule